// File: doc/BRIEF.md
# Negacyclic Number-Theoretic Transform Engine

This block holds one length-N polynomial with coefficients modulo a prime q in an internal coefficient store. On request it runs either a forward or an inverse number-theoretic transform in place on that store. The forward pass first weights coefficient i by psi^i, where psi is a primitive 2N-th root of unity. It then applies radix-2 decimation-in-time butterflies (a + w·b, a − w·b). The inverse pass applies decimation-in-frequency butterflies ((a + b), (a − b)·w^-1) in the reverse stage order. It then weights coefficient i by N^-1·psi^-i. Together the two passes give the negacyclic wrap (x^N + 1) without zero padding. All arithmetic is exact modular arithmetic.

The forward output is in bit-reversed order. The inverse input is expected in that same order. A caller multiplies two polynomials by transforming both, multiplying the results point by point, loading the products and running the inverse pass. The modulus, its roots and all constant tables are derived at elaboration from the parameters N and Q. The coefficient store is loaded and read through a simple word port while the engine is idle. One butterfly is issued per clock, and the sequencer waits between stages only until its fixed two-stage pipeline has written back.

Top module: `nttEngine`

## Requirements
- R1: After reset, done is low and every coefficient reads back as 0.
- R2: While idle, a high ldEn writes ldData to word ldAddr at the clock edge. rdData always shows the word selected by rdAddr, with no clock delay.
- R3: A forward pass on the polynomial that is c at index 0 and 0 elsewhere yields c in every word, for any c (the all-zero polynomial stays all zero).
- R4: A forward pass followed by an inverse pass returns the original coefficients exactly.
- R5: Transforming A and B forward, multiplying word by word mod q, loading the products and running the inverse yields the negacyclic product of A and B: sum of a_i·b_j with i+j=k, minus the sum with i+j=k+N, mod q.
- R6: Every value the engine writes back lies in [0, q).
- R7: done is a one-cycle pulse N + log2(N)·N/2 + 2·log2(N) + 3 clock cycles after the edge that samples start (59 for N=16), for either direction. No coefficient read is issued before an earlier write to it has landed.
- R8: A start (of either direction) arriving while a pass runs is ignored: that pass finishes with its own direction and a single done.
- R9: ldEn is ignored while a pass runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass when idle |
| inverse | input | 1 | Direction sampled with start: 0 forward, 1 inverse |
| ldEn | input | 1 | Write strobe for the coefficient store |
| ldAddr | input | log2(N) | Word written by ldEn |
| ldData | input | ceil(log2(Q)) | Coefficient value written, must be below Q |
| rdAddr | input | log2(N) | Word shown on rdData |
| rdData | output | ceil(log2(Q)) | Coefficient at rdAddr |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The bench builds the engine with N = 16 and Q = 7681, a prime with Q ≡ 1 mod 32, so a primitive 32nd root exists. Sixteen points give four butterfly stages, which is enough for every stage-boundary stall, twiddle index and bit-reversed position to be exercised. The size is also small enough for the bench to compute the schoolbook negacyclic product and the exact 59-cycle latency on its own. Thirteen-bit coefficients make products span 26 bits, so the Barrett reduction sees operands near its upper limit when the bench loads values close to q−1.

// File: rtl/nttPkg.sv
package nttPkg;

  typedef enum logic [1:0] {
    OP_SCALE_FWD = 2'd0,
    OP_SCALE_INV = 2'd1,
    OP_CT        = 2'd2,
    OP_GS        = 2'd3
  } nttOp_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic   issue;
    nttOp_e op;
  } nttStrobe_t;

  function automatic longint modPow(longint base, longint expo, longint modulus);
    longint r = 1;
    longint b = base % modulus;
    longint e = expo;
    while (e > 0) begin
      if ((e & 1) != 0) r = (r * b) % modulus;
      b = (b * b) % modulus;
      e = e >> 1;
    end
    return r;
  endfunction

  // smallest-generator primitive 2n-th root: c^n == -1 mod q
  function automatic longint findPsi(longint n, longint modulus);
    for (longint g = 2; g < modulus; g++) begin
      longint c = modPow(g, (modulus - 1) / (2 * n), modulus);
      if (modPow(c, n, modulus) == modulus - 1) return c;
    end
    return 0;
  endfunction

  function automatic int bitRev(int v, int bits);
    int r = 0;
    for (int i = 0; i < bits; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

endpackage

// File: rtl/nttRed.sv
module nttRed #(
  parameter int Q = 7681,
  localparam int W = $clog2(Q)
) (
  input  logic [2*W-1:0] prod,
  output logic [W-1:0]   res
);
  localparam int K = 2 * W;
  localparam logic [W:0] MU = (W+1)'((longint'(1) << K) / longint'(Q));

  logic [3*W:0]   est;
  logic [W:0]     qHat;
  logic [2*W-1:0] qHatQ;
  logic [2*W-1:0] r0, r1, r2;

  always_comb begin
    est   = {(W+1)'(0), prod} * {(2*W)'(0), MU};
    qHat  = est[3*W:K];
    qHatQ = {(W-1)'(0), qHat} * (2*W)'(Q);
    r0    = prod - qHatQ;
    r1    = (r0 >= (2*W)'(Q)) ? r0 - (2*W)'(Q) : r0;
    r2    = (r1 >= (2*W)'(Q)) ? r1 - (2*W)'(Q) : r1;
    res   = r2[W-1:0];
  end
endmodule

// File: rtl/nttCtrl.sv
module nttCtrl
  import nttPkg::*;
#(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          inverse,
  input  logic          pipeEmpty,
  output nttStrobe_t    strobe,
  output logic [AW-1:0] addrA,
  output logic [AW-1:0] addrB,
  output logic [AW-1:0] twIdx,
  output logic          busy,
  output logic          done
);
  localparam int L  = AW;
  localparam int PW = $clog2(L + 1) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} state_e;

  state_e        state;
  logic [PW-1:0] ph;
  logic [AW-1:0] cnt;
  logic          mode;
  logic          isScale, lastOne, hold;

  always_comb begin
    int s, len, k, j, base;
    isScale = mode ? (ph == PW'(L)) : (ph == '0);
    lastOne = isScale ? (cnt == AW'(N - 1)) : (cnt == AW'(N / 2 - 1));
    hold    = (cnt == '0) && !pipeEmpty;
    strobe.issue = (state == ST_RUN) && !hold;
    if (isScale) strobe.op = mode ? OP_SCALE_INV : OP_SCALE_FWD;
    else         strobe.op = mode ? OP_GS : OP_CT;
    s = mode ? (L - 1 - int'(ph)) : (int'(ph) - 1);
    if (s < 0) s = 0;
    if (s > L - 1) s = L - 1;
    len  = N >> (s + 1);
    k    = int'(cnt) >> (L - 1 - s);
    j    = int'(cnt) & (len - 1);
    base = (k << (L - s)) | j;
    if (isScale) begin
      addrA = cnt;
      addrB = cnt;
      twIdx = cnt;
    end else begin
      addrA = AW'(base);
      addrB = AW'(base + len);
      twIdx = AW'(k);
    end
    busy = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ph    <= '0;
      cnt   <= '0;
      mode  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          mode  <= inverse;
          ph    <= '0;
          cnt   <= '0;
        end
        ST_RUN: if (strobe.issue) begin
          if (lastOne) begin
            cnt <= '0;
            if (ph == PW'(L)) begin
              ph    <= '0;
              state <= ST_FINISH;
            end else begin
              ph <= ph + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FINISH: if (pipeEmpty) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pipeEmpty);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
endmodule

// File: rtl/nttPath.sv
module nttPath
  import nttPkg::*;
#(
  parameter int N = 16,
  parameter int Q = 7681,
  localparam int AW = $clog2(N),
  localparam int W  = $clog2(Q)
) (
  input  logic          clk,
  input  logic          rstN,
  input  nttStrobe_t    strobe,
  input  logic [AW-1:0] addrA,
  input  logic [AW-1:0] addrB,
  input  logic [AW-1:0] twIdx,
  input  logic          busy,
  input  logic          ldEn,
  input  logic [AW-1:0] ldAddr,
  input  logic [W-1:0]  ldData,
  input  logic [AW-1:0] rdAddr,
  output logic [W-1:0]  rdData,
  output logic          pipeEmpty
);
  localparam int     L    = AW;
  localparam longint PSI  = findPsi(longint'(N), longint'(Q));
  localparam longint NINV = modPow(longint'(N), longint'(Q - 2), longint'(Q));

  logic [W-1:0] preTab   [N];
  logic [W-1:0] postTab  [N];
  logic [W-1:0] twTab    [N/2];
  logic [W-1:0] twInvTab [N/2];

  for (genvar i = 0; i < N; i++) begin : g_scaleTab
    localparam longint PRE  = modPow(PSI, longint'(i), longint'(Q));
    localparam longint POST = (modPow(PSI, longint'(2 * N - i), longint'(Q)) * NINV) % longint'(Q);
    assign preTab[i]  = W'(PRE);
    assign postTab[i] = W'(POST);
  end

  for (genvar k = 0; k < N / 2; k++) begin : g_twTab
    localparam int     BR  = bitRev(k, L - 1);
    localparam longint TW  = modPow(PSI, longint'(2 * BR), longint'(Q));
    localparam longint TWI = modPow(PSI, longint'(2 * N - 2 * BR), longint'(Q));
    assign twTab[k]    = W'(TW);
    assign twInvTab[k] = W'(TWI);
  end

  function automatic logic [W-1:0] addQ(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s = {1'b0, a} + {1'b0, b};
    return (s >= (W+1)'(Q)) ? W'(s - (W+1)'(Q)) : W'(s);
  endfunction

  function automatic logic [W-1:0] subQ(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] d = (a >= b) ? {1'b0, a} - {1'b0, b} : {1'b0, a} + (W+1)'(Q) - {1'b0, b};
    return W'(d);
  endfunction

  logic [W-1:0] mem [N];

  // issue stage (combinational read)
  logic [W-1:0] opA, opB, opW, mulIn;
  // pipeline stage 1
  logic          p1Valid;
  nttOp_e        p1Op;
  logic [AW-1:0] p1AddrA, p1AddrB;
  logic [W-1:0]  p1A, p1Sum, p1MulIn, p1W;
  // pipeline stage 2
  logic           p2Valid;
  nttOp_e         p2Op;
  logic [AW-1:0]  p2AddrA, p2AddrB;
  logic [W-1:0]   p2A, p2Sum;
  logic [2*W-1:0] p2Prod;
  // writeback
  logic [W-1:0] redOut, wrA, wrB;

  always_comb begin
    opA = mem[addrA];
    opB = mem[addrB];
    case (strobe.op)
      OP_SCALE_FWD: opW = preTab[twIdx];
      OP_SCALE_INV: opW = postTab[twIdx];
      OP_CT:        opW = twTab[twIdx[AW-2:0]];
      default:      opW = twInvTab[twIdx[AW-2:0]];
    endcase
    case (strobe.op)
      OP_CT:   mulIn = opB;
      OP_GS:   mulIn = subQ(opA, opB);
      default: mulIn = opA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p1Valid <= 1'b0;
      p2Valid <= 1'b0;
      p1Op    <= OP_SCALE_FWD;
      p2Op    <= OP_SCALE_FWD;
      p1AddrA <= '0; p1AddrB <= '0; p2AddrA <= '0; p2AddrB <= '0;
      p1A     <= '0; p1Sum <= '0; p1MulIn <= '0; p1W <= '0;
      p2A     <= '0; p2Sum <= '0; p2Prod <= '0;
    end else begin
      p1Valid <= strobe.issue;
      p1Op    <= strobe.op;
      p1AddrA <= addrA;
      p1AddrB <= addrB;
      p1A     <= opA;
      p1Sum   <= addQ(opA, opB);
      p1MulIn <= mulIn;
      p1W     <= opW;
      p2Valid <= p1Valid;
      p2Op    <= p1Op;
      p2AddrA <= p1AddrA;
      p2AddrB <= p1AddrB;
      p2A     <= p1A;
      p2Sum   <= p1Sum;
      p2Prod  <= (2*W)'(p1MulIn) * (2*W)'(p1W);
    end
  end

  nttRed #(.Q(Q)) i_red (.prod(p2Prod), .res(redOut));

  always_comb begin
    case (p2Op)
      OP_CT: begin
        wrA = addQ(p2A, redOut);
        wrB = subQ(p2A, redOut);
      end
      OP_GS: begin
        wrA = p2Sum;
        wrB = redOut;
      end
      default: begin
        wrA = redOut;
        wrB = redOut;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (p2Valid) begin
      mem[p2AddrA] <= wrA;
      if (p2Op == OP_CT || p2Op == OP_GS) mem[p2AddrB] <= wrB;
    end else if (ldEn && !busy) begin
      mem[ldAddr] <= ldData;
    end
  end

  assign rdData    = mem[rdAddr];
  assign pipeEmpty = !p1Valid && !p2Valid;

  // R6
  wb_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    p2Valid |-> (wrA < W'(Q)) && (wrB < W'(Q)));

  // R7
  raw_near_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && p1Valid) |-> (addrA != p1AddrA) && (addrA != p1AddrB)
                                && (addrB != p1AddrA) && (addrB != p1AddrB));

  // R7
  raw_far_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && p2Valid) |-> (addrA != p2AddrA) && (addrA != p2AddrB)
                                && (addrB != p2AddrA) && (addrB != p2AddrB));

  // R9
  load_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (p1Valid || p2Valid) |-> busy);
endmodule

// File: rtl/nttEngine.sv
module nttEngine
  import nttPkg::*;
#(
  parameter int N = 16,
  parameter int Q = 7681,
  localparam int AW = $clog2(N),
  localparam int W  = $clog2(Q)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          inverse,
  input  logic          ldEn,
  input  logic [AW-1:0] ldAddr,
  input  logic [W-1:0]  ldData,
  input  logic [AW-1:0] rdAddr,
  output logic [W-1:0]  rdData,
  output logic          done
);
  nttStrobe_t    strobe;
  logic [AW-1:0] addrA, addrB, twIdx;
  logic          busy, pipeEmpty;

  nttCtrl #(.N(N)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inverse(inverse),
    .pipeEmpty(pipeEmpty), .strobe(strobe), .addrA(addrA), .addrB(addrB),
    .twIdx(twIdx), .busy(busy), .done(done)
  );

  nttPath #(.N(N), .Q(Q)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrA(addrA), .addrB(addrB),
    .twIdx(twIdx), .busy(busy), .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData),
    .rdAddr(rdAddr), .rdData(rdData), .pipeEmpty(pipeEmpty)
  );
endmodule

// File: tb/test_nttEngine.sv
module test_nttEngine;
  localparam int N   = 16;
  localparam int Q   = 7681;
  localparam int AW  = 4;
  localparam int W   = 13;
  localparam int LAT = 59;

  logic          clk = 1'b0;
  logic          rstN, start, inverse, ldEn, done;
  logic [AW-1:0] ldAddr, rdAddr;
  logic [W-1:0]  ldData, rdData;

  int errors = 0;
  int checks = 0;
  int seed   = 12345;

  always #2.5 clk = ~clk;

  nttEngine #(.N(N), .Q(Q)) i_nttEngine (
    .clk(clk), .rstN(rstN), .start(start), .inverse(inverse), .ldEn(ldEn),
    .ldAddr(ldAddr), .ldData(ldData), .rdAddr(rdAddr), .rdData(rdData), .done(done)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fffff) % Q;
  endfunction

  task automatic loadPoly(input int p[N]);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ldEn = 1'b1; ldAddr = AW'(i); ldData = W'(p[i]);
    end
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic readPoly(output int p[N]);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      rdAddr = AW'(i);
      #0.5;
      p[i] = int'(rdData);
    end
  endtask

  // start a pass and count cycles until done
  task automatic runPass(input logic inv, output int cycles);
    @(negedge clk);
    start = 1'b1; inverse = inv;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; inverse = 1'b0;
    cycles = 0;
    while (!done && cycles < 500) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
    if (!done) check("R7 timeout", cycles, LAT);
  endtask

  task automatic testReset();
    int r[N];
    check("R1 done after reset", done, 0);
    readPoly(r);
    for (int i = 0; i < N; i++) check("R1 coefficient after reset", r[i], 0);
  endtask

  task automatic testLoadRead();
    int p[N], r[N];
    for (int i = 0; i < N; i++) p[i] = (i * 457 + 3) % Q;
    p[N-1] = Q - 1;
    loadPoly(p);
    readPoly(r);
    for (int i = 0; i < N; i++) check("R2 load/read", r[i], p[i]);
  endtask

  task automatic testForwardKnown();
    int p[N], r[N], cyc;
    int vals[3] = '{0, 1, 5000};
    foreach (vals[v]) begin
      for (int i = 0; i < N; i++) p[i] = 0;
      p[0] = vals[v];
      loadPoly(p);
      runPass(1'b0, cyc);
      readPoly(r);
      for (int i = 0; i < N; i++) check("R3 forward of constant", r[i], vals[v]);
    end
  endtask

  task automatic testRoundTrip(input bit extreme);
    int p[N], r[N], f[N], cyc;
    for (int i = 0; i < N; i++) p[i] = extreme ? (Q - 1 - (i % 2)) : nextRand();
    loadPoly(p);
    runPass(1'b0, cyc);
    readPoly(f);
    for (int i = 0; i < N; i++) check("R6 forward range", (f[i] < Q) ? 1 : 0, 1);
    runPass(1'b1, cyc);
    readPoly(r);
    for (int i = 0; i < N; i++) check("R4 round trip", r[i], p[i]);
  endtask

  task automatic testProduct();
    int a[N], b[N], fa[N], fb[N], pc[N], r[N], cyc;
    longint acc;
    for (int i = 0; i < N; i++) begin a[i] = nextRand(); b[i] = nextRand(); end
    a[3] = Q - 1; b[N-1] = Q - 1;
    loadPoly(a); runPass(1'b0, cyc); readPoly(fa);
    loadPoly(b); runPass(1'b0, cyc); readPoly(fb);
    for (int i = 0; i < N; i++) pc[i] = int'((longint'(fa[i]) * longint'(fb[i])) % Q);
    loadPoly(pc); runPass(1'b1, cyc); readPoly(r);
    for (int k = 0; k < N; k++) begin
      acc = 0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          if (i + j == k)     acc += longint'(a[i]) * longint'(b[j]);
          if (i + j == k + N) acc -= longint'(a[i]) * longint'(b[j]);
        end
      acc = acc % Q;
      if (acc < 0) acc += Q;
      check("R5 negacyclic product", r[k], acc);
      check("R6 inverse range", (r[k] < Q) ? 1 : 0, 1);
    end
  endtask

  task automatic testLatency();
    int cyc;
    runPass(1'b0, cyc);
    check("R7 forward latency", cyc, LAT);
    @(negedge clk);
    check("R7 done single cycle", done, 0);
    runPass(1'b1, cyc);
    check("R7 inverse latency", cyc, LAT);
    @(negedge clk);
    check("R7 done single cycle", done, 0);
  endtask

  task automatic testStartBusy();
    int p[N], r[N], dones = 0, first = -1;
    for (int i = 0; i < N; i++) p[i] = 0;
    p[0] = 1;
    loadPoly(p);
    @(negedge clk);
    start = 1'b1; inverse = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 200; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 10 || c == 30) begin start = 1'b1; inverse = 1'b1; end
      else begin start = 1'b0; inverse = 1'b0; end
      if (done) begin dones++; if (first < 0) first = c; end
    end
    check("R8 one done", dones, 1);
    check("R8 done timing", first, LAT);
    readPoly(r);
    for (int i = 0; i < N; i++) check("R8 direction kept", r[i], 1);
  endtask

  task automatic testLoadBusy();
    int p[N], r[N];
    for (int i = 0; i < N; i++) p[i] = 0;
    p[0] = 7;
    loadPoly(p);
    @(negedge clk);
    start = 1'b1; inverse = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c < 500 && !done; c++) begin
      ldEn   = (c == 5 || c == 40);
      ldAddr = (c == 5) ? AW'(0) : AW'(5);
      ldData = W'(1234);
      @(posedge clk);
      @(negedge clk);
    end
    ldEn = 1'b0;
    readPoly(r);
    for (int i = 0; i < N; i++) check("R9 load ignored", r[i], 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; inverse = 1'b0; ldEn = 1'b0;
    ldAddr = '0; ldData = '0; rdAddr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLoadRead();
    testForwardKnown();
    testRoundTrip(1'b0);
    testRoundTrip(1'b1);
    testRoundTrip(1'b0);
    testProduct();
    testProduct();
    testLatency();
    testStartBusy();
    testLoadBusy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule